// File: doc/BRIEF.md
# Dual-Frequency Summed Reference Generator

This block produces the four modulation references for a reduced-leg three-level inverter. One leg is common to a single-phase output and a three-phase output, so every reference is the sum of a single-phase sinusoid and a three-phase sinusoid. The two systems can run at independent frequencies. Two phase accumulators advance by their own tuning words. Five sine lookups read the accumulated phases with fixed phase offsets applied. Each lookup result is scaled by the amplitude of its system, and the scaled terms are summed per leg.

On every sample strobe the block registers four signed fixed-point references together: the common leg, the extra single-phase leg, and the two remaining three-phase legs. A downstream carrier comparator consumes them. The same strobe also registers a flag. The flag reports whether the amplitude pair is outside the linear range allowed by the current operating mode. That mode is equal frequencies or unequal frequencies, depending on whether the two tuning words match.

Top module: `dfref_gen`

## Requirements
- R1: Reset clears both phase accumulators, all four references, `out_valid` and `limit_violation` to zero. As a result, the first sample after reset is taken at phase zero for both systems.
- R2: On each cycle with `sample_strobe` high, the references are formed from the accumulator phases held before that edge. Each accumulator then advances by its tuning word, modulo 2^32. Without a strobe, both accumulators hold.
- R3: `ref_shared` = m1·sin(θ1) + m2·sin(θ2).
  - The sine argument is the top 10 bits k of a 32-bit phase word, taken as angle 2πk/1024.
  - Amplitudes are unsigned Q2.14, with 16384 = 1.0.
  - References are signed 19-bit values with 14 fraction bits.
  - Each reference is within 4 LSB of the exact value.
- R4: `ref_d` = m1·sin(θ1 + 180°) + m2·sin(θ2). The 180° offset is the phase word 0x8000_0000, added to accumulator 1.
- R5: `ref_b` = m2·sin(θ2 − 120°) + m1·sin(θ1), with 0x5555_5555 subtracted from accumulator 2. `ref_c` = m2·sin(θ2 + 120°) + m1·sin(θ1), with 0x5555_5555 added to accumulator 2.
- R6: With m2 = 0, `ref_b` and `ref_c` both equal `ref_shared`. `ref_d` then carries only the inverted single-phase term.
- R7: `out_valid` is high exactly in the cycle after each strobe. The four references change only on a strobe edge and hold their values between strobes.
- R8: When `ftw1` ≠ `ftw2` at the strobe, `limit_violation` is set exactly when m1 + m2 > 24769 (1.5118 in Q2.14).
- R9: When `ftw1` = `ftw2` at the strobe, `limit_violation` is set exactly when m1 > 16384 (1.0) or m2 > 18919 (1.1547).
- R10: `limit_violation` is registered only on a strobe edge. Amplitude or tuning-word changes between strobes do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_strobe | input | 1 | Take a sample and advance both phases |
| ftw1 | input | 32 | Tuning word of the single-phase system |
| ftw2 | input | 32 | Tuning word of the three-phase system |
| m1 | input | 16 | Single-phase amplitude, unsigned Q2.14 |
| m2 | input | 16 | Three-phase amplitude, unsigned Q2.14 |
| ref_shared | output | 19 | Common-leg reference, signed Q5.14 |
| ref_d | output | 19 | Single-phase second-leg reference |
| ref_b | output | 19 | Three-phase leg b reference |
| ref_c | output | 19 | Three-phase leg c reference |
| out_valid | output | 1 | High one cycle after a strobe |
| limit_violation | output | 1 | Amplitude pair outside the mode's linear range |

## Verification
The references are compared against a sine model in the bench under several input patterns:
- Equal tuning words at the peak amplitudes. This shows whether the two terms are summed with the right offsets when the phases move together.
- Distinct tuning words. These separate an offset applied to the wrong accumulator from one applied to the right one.
- A zero three-phase amplitude. This isolates the single-phase term and its 180° inversion.
- A tuning word near 2^32. This exercises modular wrap of the phase.

The limit flag is driven to just below and just above each threshold in both modes. The same amplitudes are also applied once with equal and once with unequal tuning words, which shows that the mode selects the rule. Idle gaps and a mid-run reset confirm that state holds between strobes and restarts at phase zero.

// File: rtl/dfref_pkg.sv
package dfref_pkg;

  // pi scaled by 2^28, rounded
  localparam longint PI_Q28 = 64'sd843314857;

  // Sine of (i * 2*pi / 2^idx_w) for 0 <= i <= 2^(idx_w-2), rounded to frac bits.
  // Evaluated with a Taylor series in 2^-28 fixed point at elaboration time.
  function automatic longint quarter_sine(int i, int idx_w, int frac);
    longint x;
    longint x2;
    longint term;
    longint sum;
    x    = (longint'(i) * PI_Q28) >>> (idx_w - 1);
    x2   = (x * x) >>> 28;
    term = x;
    sum  = x;
    for (int k = 1; k <= 7; k++) begin
      term = -((term * x2) >>> 28) / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    return (sum + (longint'(1) <<< (27 - frac))) >>> (28 - frac);
  endfunction

  // One third of a full turn, rounded to nearest, for a phase_w-bit word
  function automatic longint third_turn(int phase_w);
    return ((longint'(1) <<< phase_w) + 64'sd1) / 64'sd3;
  endfunction

endpackage

// File: rtl/dfref_phase_acc.sv
module dfref_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [PHASE_W-1:0] ftw,
  output logic [PHASE_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (adv) begin
      phase <= phase + ftw;
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && $past(rst_n)) |=> $stable(phase)); // R2

endmodule

// File: rtl/dfref_sine_rom.sv
module dfref_sine_rom #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10,
  parameter int SIN_W   = 16,
  parameter int FRAC    = 14
) (
  input  logic [PHASE_W-1:0]      phase_word,
  output logic signed [SIN_W-1:0] sine
);

  localparam int Q_W = IDX_W - 2;
  localparam int QN  = 1 << Q_W;

  logic signed [SIN_W-1:0] qtab [QN+1];

  for (genvar i = 0; i <= QN; i++) begin : g_tab
    localparam logic signed [SIN_W-1:0] VAL =
      SIN_W'(dfref_pkg::quarter_sine(i, IDX_W, FRAC));
    assign qtab[i] = VAL;
  end

  logic [IDX_W-1:0]        idx;
  logic [Q_W-1:0]          off;
  logic [Q_W:0]            mirror_idx;
  logic signed [SIN_W-1:0] mag;
  logic                    second_half;

  assign idx         = phase_word[PHASE_W-1 -: IDX_W];
  assign off         = idx[Q_W-1:0];
  assign second_half = idx[IDX_W-1];

  always_comb begin
    if (idx[IDX_W-2]) begin
      mirror_idx = (Q_W+1)'(QN) - {1'b0, off};
    end else begin
      mirror_idx = {1'b0, off};
    end
  end

  assign mag  = qtab[mirror_idx];
  assign sine = second_half ? -mag : mag;

endmodule

// File: rtl/dfref_lane.sv
module dfref_lane #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10,
  parameter int SIN_W   = 16,
  parameter int AMP_W   = 16,
  parameter int FRAC    = 14,
  parameter int OUT_W   = 19
) (
  input  logic [PHASE_W-1:0]      phase_word,
  input  logic [AMP_W-1:0]        amp,
  output logic signed [OUT_W-1:0] term
);

  localparam int PROD_W = AMP_W + SIN_W + 1;

  logic signed [SIN_W-1:0] sine;

  dfref_sine_rom #(
    .PHASE_W (PHASE_W),
    .IDX_W   (IDX_W),
    .SIN_W   (SIN_W),
    .FRAC    (FRAC)
  ) u_rom (
    .phase_word (phase_word),
    .sine       (sine)
  );

  // amplitude times sine, rounded half up back to FRAC fraction bits
  function automatic logic signed [OUT_W-1:0] scale_round(
    input logic [AMP_W-1:0]        a,
    input logic signed [SIN_W-1:0] s
  );
    logic signed [PROD_W-1:0] p;
    p = $signed({1'b0, a}) * s;
    p = p + (PROD_W'(1) <<< (FRAC - 1));
    return OUT_W'(p >>> FRAC);
  endfunction

  assign term = scale_round(amp, sine);

endmodule

// File: rtl/dfref_limit.sv
module dfref_limit #(
  parameter int PHASE_W = 32,
  parameter int AMP_W   = 16,
  parameter int LIM_SUM = 24769,
  parameter int LIM_M1  = 16384,
  parameter int LIM_M2  = 18919
) (
  input  logic [PHASE_W-1:0] ftw1,
  input  logic [PHASE_W-1:0] ftw2,
  input  logic [AMP_W-1:0]   m1,
  input  logic [AMP_W-1:0]   m2,
  output logic               over
);

  logic [AMP_W:0] amp_sum;
  logic           split_freq;
  logic           sum_over;
  logic           single_over;

  assign amp_sum     = {1'b0, m1} + {1'b0, m2};
  assign split_freq  = (ftw1 != ftw2);
  assign sum_over    = amp_sum > (AMP_W+1)'(LIM_SUM);
  assign single_over = (m1 > AMP_W'(LIM_M1)) || (m2 > AMP_W'(LIM_M2));
  assign over        = split_freq ? sum_over : single_over;

endmodule

// File: rtl/dfref_gen.sv
module dfref_gen #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10,
  parameter int SIN_W   = 16,
  parameter int AMP_W   = 16,
  parameter int FRAC    = 14,
  parameter int OUT_W   = 19,
  parameter int LIM_SUM = 24769,
  parameter int LIM_M1  = 16384,
  parameter int LIM_M2  = 18919
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_strobe,
  input  logic [PHASE_W-1:0]      ftw1,
  input  logic [PHASE_W-1:0]      ftw2,
  input  logic [AMP_W-1:0]        m1,
  input  logic [AMP_W-1:0]        m2,
  output logic signed [OUT_W-1:0] ref_shared,
  output logic signed [OUT_W-1:0] ref_d,
  output logic signed [OUT_W-1:0] ref_b,
  output logic signed [OUT_W-1:0] ref_c,
  output logic                    out_valid,
  output logic                    limit_violation
);

  // lane 0: theta1, lane 1: theta1+180, lane 2: theta2, lane 3: theta2-120, lane 4: theta2+120
  localparam int LANES = 5;
  localparam logic [PHASE_W-1:0] OFS_HALF = PHASE_W'(1) << (PHASE_W - 1);
  localparam logic [PHASE_W-1:0] OFS_P120 = PHASE_W'(dfref_pkg::third_turn(PHASE_W));
  localparam logic [PHASE_W-1:0] OFS_M120 = PHASE_W'(0) - OFS_P120;

  function automatic logic [PHASE_W-1:0] lane_ofs(int g);
    case (g)
      1:       return OFS_HALF;
      3:       return OFS_M120;
      4:       return OFS_P120;
      default: return '0;
    endcase
  endfunction

  logic [PHASE_W-1:0]      acc1;
  logic [PHASE_W-1:0]      acc2;
  logic signed [OUT_W-1:0] lane_term [LANES];
  logic                    limit_now;

  dfref_phase_acc #(.PHASE_W(PHASE_W)) u_acc1 (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (sample_strobe),
    .ftw   (ftw1),
    .phase (acc1)
  );

  dfref_phase_acc #(.PHASE_W(PHASE_W)) u_acc2 (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (sample_strobe),
    .ftw   (ftw2),
    .phase (acc2)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [PHASE_W-1:0] OFS = lane_ofs(g);
    logic [PHASE_W-1:0]      base;
    logic [PHASE_W-1:0]      lane_phase;
    logic [AMP_W-1:0]        amp;
    logic signed [OUT_W-1:0] amp_bound;

    if (g < 2) begin : g_sys1
      assign base = acc1;
      assign amp  = m1;
    end else begin : g_sys3
      assign base = acc2;
      assign amp  = m2;
    end

    assign lane_phase = base + OFS;
    assign amp_bound  = OUT_W'(amp) + OUT_W'(1);

    dfref_lane #(
      .PHASE_W (PHASE_W),
      .IDX_W   (IDX_W),
      .SIN_W   (SIN_W),
      .AMP_W   (AMP_W),
      .FRAC    (FRAC),
      .OUT_W   (OUT_W)
    ) u_lane (
      .phase_word (lane_phase),
      .amp        (amp),
      .term       (lane_term[g])
    );

    AST_TERM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_term[g] <= amp_bound) && (lane_term[g] >= -amp_bound)); // R3
  end

  dfref_limit #(
    .PHASE_W (PHASE_W),
    .AMP_W   (AMP_W),
    .LIM_SUM (LIM_SUM),
    .LIM_M1  (LIM_M1),
    .LIM_M2  (LIM_M2)
  ) u_limit (
    .ftw1 (ftw1),
    .ftw2 (ftw2),
    .m1   (m1),
    .m2   (m2),
    .over (limit_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_shared      <= '0;
      ref_d           <= '0;
      ref_b           <= '0;
      ref_c           <= '0;
      out_valid       <= 1'b0;
      limit_violation <= 1'b0;
    end else begin
      out_valid <= sample_strobe;
      if (sample_strobe) begin
        ref_shared      <= lane_term[0] + lane_term[2];
        ref_d           <= lane_term[1] + lane_term[2];
        ref_b           <= lane_term[3] + lane_term[0];
        ref_c           <= lane_term[4] + lane_term[0];
        limit_violation <= limit_now;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> out_valid); // R7

  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> !out_valid); // R7

  AST_HOLD_REFS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_strobe && $past(rst_n)) |=> ($stable(ref_shared) && $stable(ref_d)
                        && $stable(ref_b) && $stable(ref_c))); // R7

  AST_LIMIT_SPLIT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && (ftw1 != ftw2) &&
     (({1'b0, m1} + {1'b0, m2}) <= (AMP_W+1)'(LIM_SUM))) |=> !limit_violation); // R8

  AST_LIMIT_SAME_M1: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && (ftw1 == ftw2) && (m1 > AMP_W'(LIM_M1))) |=> limit_violation); // R9

  AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_strobe && $past(rst_n)) |=> $stable(limit_violation)); // R10

endmodule

// File: tb/dfref_gen_tb.sv
module dfref_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam real TOL = 4.0;
  localparam real TWO_PI = 6.283185307179586;
  localparam logic [31:0] THIRD = 32'h5555_5555;
  localparam logic [31:0] HALF  = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_strobe = 1'b0;
  logic [31:0] ftw1 = '0;
  logic [31:0] ftw2 = '0;
  logic [15:0] m1 = '0;
  logic [15:0] m2 = '0;
  logic signed [18:0] ref_shared, ref_d, ref_b, ref_c;
  logic        out_valid, limit_violation;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] a1 = '0;
  logic [31:0] a2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfref_gen u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_strobe   (sample_strobe),
    .ftw1            (ftw1),
    .ftw2            (ftw2),
    .m1              (m1),
    .m2              (m2),
    .ref_shared      (ref_shared),
    .ref_d           (ref_d),
    .ref_b           (ref_b),
    .ref_c           (ref_c),
    .out_valid       (out_valid),
    .limit_violation (limit_violation)
  );

  function automatic real sine_term(int amp, logic [31:0] w);
    int k;
    k = int'(w[31:22]);
    return real'(amp) * $sin(TWO_PI * real'(k) / 1024.0);
  endfunction

  task automatic chk_near(string req, string what, int act, real exp);
    real d;
    vectors++;
    d = real'(act) - exp;
    if (d > TOL || d < -TOL) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_limit();
    if (ftw1 != ftw2) return ((int'(m1) + int'(m2)) > 24769) ? 1 : 0;
    return (int'(m1) > 16384 || int'(m2) > 18919) ? 1 : 0;
  endfunction

  // one strobe with the current inputs; checks every output; advances the model
  task automatic do_sample(string req);
    real s1, s1h, s2, s2m, s2p;
    int  lim;
    s1  = sine_term(int'(m1), a1);
    s1h = sine_term(int'(m1), a1 + HALF);
    s2  = sine_term(int'(m2), a2);
    s2m = sine_term(int'(m2), a2 - THIRD);
    s2p = sine_term(int'(m2), a2 + THIRD);
    lim = exp_limit();
    @(negedge clk);
    sample_strobe = 1'b1;
    @(negedge clk);
    sample_strobe = 1'b0;
    chk_near({req, " R3"}, "ref_shared", int'(ref_shared), s1 + s2);
    chk_near({req, " R4"}, "ref_d", int'(ref_d), s1h + s2);
    chk_near({req, " R5"}, "ref_b", int'(ref_b), s2m + s1);
    chk_near({req, " R5"}, "ref_c", int'(ref_c), s2p + s1);
    chk_eq({req, " R7"}, "out_valid", int'(out_valid), 1);
    chk_eq({req, " R8/R9"}, "limit_violation", int'(limit_violation), lim);
    a1 = a1 + ftw1;
    a2 = a2 + ftw2;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    a1 = '0;
    a2 = '0;
  endtask

  task automatic t_reset_state();
    apply_reset();
    @(negedge clk);
    chk_eq("R1", "ref_shared", int'(ref_shared), 0);
    chk_eq("R1", "ref_d", int'(ref_d), 0);
    chk_eq("R1", "ref_b", int'(ref_b), 0);
    chk_eq("R1", "ref_c", int'(ref_c), 0);
    chk_eq("R1", "out_valid", int'(out_valid), 0);
    chk_eq("R1", "limit_violation", int'(limit_violation), 0);
  endtask

  task automatic t_same_freq();
    ftw1 = 32'h0200_0000;
    ftw2 = 32'h0200_0000;
    m1 = 16'd16384;
    m2 = 16'd18919;
    do_sample("R1 first");
    for (int i = 0; i < 10; i++) do_sample("R2 same");
  endtask

  task automatic t_diff_freq();
    ftw1 = 32'h0123_4567;
    ftw2 = 32'h0346_8ACF;
    m1 = 16'd12384;
    m2 = 16'd12385;
    for (int i = 0; i < 12; i++) do_sample("R2 diff");
    m2 = 16'd12386;
    do_sample("R8 over");
  endtask

  task automatic t_single_only();
    ftw1 = 32'h0AB0_0000;
    ftw2 = 32'h0510_0000;
    m1 = 16'd15000;
    m2 = 16'd0;
    for (int i = 0; i < 4; i++) begin
      do_sample("R6");
      chk_eq("R6", "ref_b vs ref_shared", int'(ref_b), int'(ref_shared));
      chk_eq("R6", "ref_c vs ref_shared", int'(ref_c), int'(ref_shared));
    end
  endtask

  task automatic t_hold_between();
    int hs, hd, hb, hc, hl;
    ftw1 = 32'h0700_0000;
    ftw2 = 32'h0300_0000;
    m1 = 16'd16000;
    m2 = 16'd14000;
    do_sample("R8 hold");
    hs = int'(ref_shared); hd = int'(ref_d);
    hb = int'(ref_b); hc = int'(ref_c); hl = int'(limit_violation);
    m1 = 16'd1000;
    m2 = 16'd1000;
    ftw2 = 32'h0700_0000;
    repeat (6) @(negedge clk);
    chk_eq("R7", "idle out_valid", int'(out_valid), 0);
    chk_eq("R7", "idle ref_shared", int'(ref_shared), hs);
    chk_eq("R7", "idle ref_d", int'(ref_d), hd);
    chk_eq("R7", "idle ref_b", int'(ref_b), hb);
    chk_eq("R7", "idle ref_c", int'(ref_c), hc);
    chk_eq("R10", "idle limit", int'(limit_violation), hl);
    ftw2 = 32'h0300_0000;
    m1 = 16'd16000;
    m2 = 16'd14000;
    do_sample("R2 resume");
  endtask

  task automatic t_limit_edges();
    ftw1 = 32'h0100_0000;
    ftw2 = 32'h0100_0000;
    m1 = 16'd16385; m2 = 16'd0;
    do_sample("R9 m1 over");
    m1 = 16'd16384; m2 = 16'd18920;
    do_sample("R9 m2 over");
    m1 = 16'd16384; m2 = 16'd18919;
    do_sample("R9 at edge");
    ftw2 = 32'h0180_0000;
    m1 = 16'd16385; m2 = 16'd0;
    do_sample("R8 split ok");
    m1 = 16'd12000; m2 = 16'd12770;
    do_sample("R8 split over");
  endtask

  task automatic t_wrap();
    ftw1 = 32'hF000_0000;
    ftw2 = 32'hFFC0_1234;
    m1 = 16'd10000;
    m2 = 16'd11000;
    for (int i = 0; i < 8; i++) do_sample("R2 wrap");
  endtask

  task automatic t_reset_restart();
    apply_reset();
    @(negedge clk);
    chk_eq("R1", "reset again valid", int'(out_valid), 0);
    ftw1 = 32'h0400_0000;
    ftw2 = 32'h0600_0000;
    m1 = 16'd12000;
    m2 = 16'd12000;
    do_sample("R1 restart");
    do_sample("R2 restart");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset_state();
    t_same_freq();
    t_diff_freq();
    t_single_only();
    t_hold_between();
    t_limit_edges();
    t_wrap();
    t_reset_restart();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule